// File: doc/BRIEF.md
# Byte-Addressed Data Memory with Selectable Byte Order

This block is a small data memory addressed one byte at a time, with a 32-bit data port. A single request can move a byte, a halfword or a word. A mode input picks how the bytes of a multi-byte value are laid out over consecutive addresses. In big-endian order the most significant byte sits at the lowest address. In little-endian order the least significant byte sits at the lowest address. The mode can change from one cycle to the next, so data stored in one order and fetched in the other comes back with its bytes reversed.

Stores are written on the rising clock edge. The read port is combinational: it always shows the value at the present address, size and mode. Halfword and byte results are zero-extended to 32 bits. A halfword must start on an even address and a word on a multiple of four. The block flags any access that breaks this rule. Such an access writes nothing and reads as zero.

The storage is split into four byte-wide columns, one for each byte lane of a word. A lane controller works out which columns an access touches and routes each byte to the right lane for the selected order.

Top module: `bmem_endian`

## Requirements
- R1: Reset (rst_n low) clears every byte of storage to 0x00; after reset any aligned read returns zero.
- R2: The size code is 0 for byte, 1 for halfword and 2 for word. Code 3 is reserved: a request with it raises misalign, writes nothing and reads as zero.
- R3: In little-endian mode (big_end = 0), byte k of the accessed value (bits 8k+7..8k) sits at address addr+k. Storing 0x87654321 at address 0 puts 0x21, 0x43, 0x65, 0x87 at addresses 0..3.
- R4: In big-endian mode (big_end = 1), the most significant byte sits at addr and the least significant byte at the highest address of the access. Storing 0x87654321 at address 0 puts 0x87, 0x65, 0x43, 0x21 at addresses 0..3.
- R5: A store with req = 1, we = 1 and an aligned address changes storage at the next rising edge. rdata is combinational in addr, size and big_end, so it shows the old contents during the store cycle and the new contents from the following cycle.
- R6: Byte reads drive rdata[31:8] to zero, and halfword reads drive rdata[31:16] to zero.
- R7: When req = 1, misalign is high in the same cycle for a halfword at an odd address or a word whose addr[1:0] is not 0.
- R8: A misaligned store or a reserved-size store leaves every byte of storage unchanged.
- R9: A misaligned or reserved-size read returns 0x00000000 on rdata.
- R10: A word stored in one mode and read back in the other mode returns with its four bytes in reversed order.
- R11: With req = 0, misalign stays low and nothing is written, whatever we and addr hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears storage |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = store, 0 = load (meaningful with req) |
| addr | input | AW | Byte address of the lowest byte of the access |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| big_end | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| wdata | input | 32 | Store value, right-justified for byte and halfword |
| rdata | output | 32 | Load value, zero-extended; zero on a bad access |
| misalign | output | 1 | High in the cycle of a requested misaligned or reserved-size access |

## Verification
rdata and misalign depend only on the present inputs and storage, so they are due in the same cycle the stimulus is applied. A store shows on rdata one rising edge later. The bench drives inputs just after the falling edge and compares both outputs against a byte-array model 2 ns later. It applies a store to the model only after that comparison, so the next comparison sees both the model and the design one edge further on. Directed literal checks cover the two byte orders, the mode swap and the alignment faults. A long stretch of random requests is then compared against the model on every clock.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    // Number of bytes moved by one access; zero marks the reserved code.
    function automatic int span_of(acc_size_e s);
        unique case (s)
            ACC_BYTE: return 1;
            ACC_HALF: return 2;
            ACC_WORD: return 4;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/bmem_bank.sv
// One byte-wide column of storage: holds byte lane (addr % 4) of every row.
module bmem_bank #(
    parameter int ROWS = 16,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [RW-1:0] row,
    input  logic [7:0]    din,
    output logic [7:0]    dout
);

    logic [7:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                cells[r] <= 8'h00;
            end
        end else if (wr) begin
            cells[row] <= din;
        end
    end

    assign dout = cells[row];

endmodule

// File: rtl/bmem_lane_ctl.sv
// Alignment check, lane enables and byte steering for both byte orders.
module bmem_lane_ctl
    import bmem_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                  req,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [1:0]            size,
    input  logic                  big_end,
    input  logic [31:0]           wdata,
    input  logic [LANES-1:0][7:0] lane_rd,
    output logic [LANES-1:0]      lane_we,
    output logic [LANES-1:0][7:0] lane_wd,
    output logic [31:0]           rdata,
    output logic                  misalign
);

    int   span;
    int   col;
    int   k;
    int   src;
    logic bad;

    always_comb begin
        span    = span_of(acc_size_e'(size));
        col     = int'(addr[1:0]);
        bad     = (span == 0) ? 1'b1 : ((col & (span - 1)) != 0);
        rdata   = '0;
        lane_we = '0;
        lane_wd = '0;
        k       = 0;
        src     = 0;
        for (int i = 0; i < LANES; i++) begin
            k = i - col;
            if (!bad && k >= 0 && k < span) begin
                // byte index within the value that belongs at address addr+k
                src                = big_end ? (span - 1 - k) : k;
                lane_wd[i]         = wdata[8*src +: 8];
                rdata[8*src +: 8]  = lane_rd[i];
                lane_we[i]         = req & we;
            end
        end
        misalign = req & bad;
    end

endmodule

// File: rtl/bmem_endian.sv
module bmem_endian
    import bmem_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int ROWS = DEPTH / LANES,
    localparam int RW   = AW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          big_end,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          misalign
);

    logic [LANES-1:0]      lane_we;
    logic [LANES-1:0][7:0] lane_wd;
    logic [LANES-1:0][7:0] lane_rd;
    logic [RW-1:0]         row;

    assign row = addr[AW-1:2];

    bmem_lane_ctl #(.AW(AW)) u_ctl (
        .req      (req),
        .we       (we),
        .addr     (addr),
        .size     (size),
        .big_end  (big_end),
        .wdata    (wdata),
        .lane_rd  (lane_rd),
        .lane_we  (lane_we),
        .lane_wd  (lane_wd),
        .rdata    (rdata),
        .misalign (misalign)
    );

    for (genvar c = 0; c < LANES; c++) begin : g_col
        bmem_bank #(.ROWS(ROWS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (lane_we[c]),
            .row   (row),
            .din   (lane_wd[c]),
            .dout  (lane_rd[c])
        );
    end

endmodule

// File: rtl/bmem_endian_chk.sv
module bmem_endian_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          we,
    input logic [AW-1:0] addr,
    input logic [1:0]    size,
    input logic          big_end,
    input logic [31:0]   wdata,
    input logic [31:0]   rdata,
    input logic          misalign,
    input logic [3:0]    lane_we
);

    assert_no_write_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (lane_we == 4'b0000));

    assert_rsvd_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size == 2'd3) |-> misalign);

    assert_word_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size == 2'd2 && addr[1:0] != 2'b00) |-> misalign);

    assert_half_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size == 2'd1 && addr[0]) |-> misalign);

    assert_byte_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'd0) |-> (rdata[31:8] == 24'h0));

    assert_half_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'd1) |-> (rdata[31:16] == 16'h0));

    assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'd2 && addr[1:0] != 2'b00) |-> (rdata == 32'h0));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (!misalign && lane_we == 4'b0000));

    assert_word_roundtrip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && size == 2'd2 && !misalign) |=>
        ((addr != $past(addr)) || (size != $past(size)) ||
         (big_end != $past(big_end)) || (rdata == $past(wdata))));

endmodule

bind bmem_endian bmem_endian_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .we       (we),
    .addr     (addr),
    .size     (size),
    .big_end  (big_end),
    .wdata    (wdata),
    .rdata    (rdata),
    .misalign (misalign),
    .lane_we  (lane_we)
);

// File: tb/bmem_endian_tb.sv
module bmem_endian_tb;

    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req;
    logic          we;
    logic [AW-1:0] addr;
    logic [1:0]    size;
    logic          big_end;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic          misalign;

    logic [7:0] mdl [DEPTH];
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    bmem_endian #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .size(size), .big_end(big_end), .wdata(wdata),
        .rdata(rdata), .misalign(misalign)
    );

    function automatic int span(logic [1:0] s);
        case (s)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit faulty(logic [AW-1:0] a, logic [1:0] s);
        int n = span(s);
        if (n == 0) return 1'b1;
        return (int'(a) % n) != 0;
    endfunction

    function automatic logic [31:0] model_read(logic [AW-1:0] a, logic [1:0] s, logic b);
        logic [31:0] r = '0;
        int n = span(s);
        if (faulty(a, s)) return 32'h0;
        for (int k = 0; k < n; k++) begin
            if (b) r[8*(n-1-k) +: 8] = mdl[int'(a) + k];
            else   r[8*k +: 8]       = mdl[int'(a) + k];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one cycle, compare against the model, then apply any store to the model.
    task automatic cycle(string tag, logic r, logic w, logic [AW-1:0] a,
                         logic [1:0] s, logic b, logic [31:0] d);
        int n;
        @(negedge clk);
        req = r; we = w; addr = a; size = s; big_end = b; wdata = d;
        #2;
        check(tag, rdata, model_read(a, s, b));
        check(tag, {31'b0, misalign}, {31'b0, (r && faulty(a, s))});
        if (r && w && !faulty(a, s)) begin
            n = span(s);
            for (int k = 0; k < n; k++) begin
                if (b) mdl[int'(a) + k] = d[8*(n-1-k) +: 8];
                else   mdl[int'(a) + k] = d[8*k +: 8];
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = 1'b0; we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; size = 2'd0;
        big_end = 1'b0; wdata = '0;
        do_reset();

        // R1: all storage reads back zero after reset
        for (int a = 0; a < DEPTH; a += 4) begin
            cycle("R1", 1'b0, 1'b0, AW'(a), 2'd2, 1'b0, 32'h0);
            check("R1", rdata, 32'h0);
        end

        // R3: little-endian word store at 0, byte reads 21 43 65 87
        cycle("R3", 1'b1, 1'b1, 6'd0, 2'd2, 1'b0, 32'h87654321);
        check("R5", rdata, 32'h0);                      // old contents during store cycle
        cycle("R3", 1'b0, 1'b0, 6'd0, 2'd0, 1'b0, 32'h0); check("R3", rdata, 32'h21);
        cycle("R3", 1'b0, 1'b0, 6'd1, 2'd0, 1'b0, 32'h0); check("R3", rdata, 32'h43);
        cycle("R3", 1'b0, 1'b0, 6'd2, 2'd0, 1'b0, 32'h0); check("R3", rdata, 32'h65);
        cycle("R3", 1'b0, 1'b0, 6'd3, 2'd0, 1'b0, 32'h0); check("R3", rdata, 32'h87);

        // R4: big-endian word store at 4, byte reads 87 65 43 21
        cycle("R4", 1'b1, 1'b1, 6'd4, 2'd2, 1'b1, 32'h87654321);
        cycle("R4", 1'b0, 1'b0, 6'd4, 2'd0, 1'b1, 32'h0); check("R4", rdata, 32'h87);
        cycle("R4", 1'b0, 1'b0, 6'd7, 2'd0, 1'b1, 32'h0); check("R4", rdata, 32'h21);

        // R10: opposite-mode word reads show reversed bytes
        cycle("R10", 1'b1, 1'b0, 6'd4, 2'd2, 1'b0, 32'h0); check("R10", rdata, 32'h21436587);
        cycle("R10", 1'b1, 1'b0, 6'd0, 2'd2, 1'b1, 32'h0); check("R10", rdata, 32'h21436587);

        // R2 / R6: halfword store and zero-extended halfword read
        cycle("R2", 1'b1, 1'b1, 6'd10, 2'd1, 1'b1, 32'hFFFFA1B2);
        cycle("R6", 1'b1, 1'b0, 6'd10, 2'd1, 1'b1, 32'h0); check("R6", rdata, 32'h0000A1B2);
        cycle("R6", 1'b1, 1'b0, 6'd10, 2'd1, 1'b0, 32'h0); check("R6", rdata, 32'h0000B2A1);
        cycle("R6", 1'b1, 1'b0, 6'd11, 2'd0, 1'b0, 32'h0); check("R6", rdata, 32'h000000B2);

        // R7 / R8: misaligned halfword store flags and writes nothing
        cycle("R7", 1'b1, 1'b1, 6'd9, 2'd1, 1'b0, 32'h0000CCDD);
        check("R7", {31'b0, misalign}, 32'h1);
        cycle("R8", 1'b1, 1'b0, 6'd8, 2'd2, 1'b0, 32'h0); check("R8", rdata, 32'hB2A10000);

        // R2 / R8: reserved size flags, no write
        cycle("R2", 1'b1, 1'b1, 6'd8, 2'd3, 1'b0, 32'hDEADBEEF);
        check("R2", {31'b0, misalign}, 32'h1);
        cycle("R8", 1'b1, 1'b0, 6'd8, 2'd2, 1'b0, 32'h0); check("R8", rdata, 32'hB2A10000);

        // R9: misaligned word read returns zero
        cycle("R9", 1'b1, 1'b0, 6'd5, 2'd2, 1'b1, 32'h0); check("R9", rdata, 32'h0);

        // R11: no request, no flag, no write
        cycle("R11", 1'b0, 1'b1, 6'd6, 2'd2, 1'b0, 32'h12345678);
        check("R11", {31'b0, misalign}, 32'h0);
        cycle("R11", 1'b0, 1'b1, 6'd4, 2'd2, 1'b1, 32'h12345678);
        cycle("R11", 1'b0, 1'b0, 6'd4, 2'd2, 1'b1, 32'h0); check("R11", rdata, 32'h87654321);

        // R5: random traffic compared with the model every clock
        for (int i = 0; i < 600; i++) begin
            cycle("R5", ($urandom_range(3) != 0), $urandom_range(1) == 1,
                  AW'($urandom_range(DEPTH - 1)), 2'($urandom_range(3)),
                  $urandom_range(1) == 1, $urandom);
        end

        // R1: reset again after traffic
        do_reset();
        for (int a = 0; a < DEPTH; a += 4) begin
            cycle("R1", 1'b1, 1'b0, AW'(a), 2'd2, 1'b1, 32'h0);
            check("R1", rdata, 32'h0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule